// File: doc/BRIEF.md
# Board control register file

This block is the memory-mapped control and status register set of a development board. A host reaches it over a simple 32-bit read/write bus. Only the low 20 address bits are decoded. The block provides fixed identification words, an 8-LED bar, an 8-character text display buffer and a break/reset byte. It also has a general-purpose output byte, a trigger that requests a soft reset when it sees a magic value, and a bit-bang I2C register set that drives clock and data lines toward a serial EEPROM and reads its data line back.

Writes take effect at the clock edge on which the bus presents them. Reads are registered: data and a valid flag appear one cycle after the read request. The display buffer is brought out as one 64-bit word, with a one-cycle pulse after every change. A host can fill the display character by character, or fill all eight characters from a single 32-bit word rendered as hexadecimal text.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits [19:0] are decoded. A read of an offset not listed here returns 0, and a write to one changes no output and no readable register.
- R2: The switch word (0x200) and the jumper word (0x210) always read 0, and writes to them are ignored. The status word (0x208) reads 0x10, or 0x12 when the parameter BIG_ENDIAN is 1. Offsets that are only written (0x410, 0x418 to 0x450, 0x500) read 0.
- R3: `bus_rvalid` is high in the cycle after every cycle with `bus_rd` high, and `bus_rdata` carries the value selected in that earlier cycle.
- R4: A write keeps only part of the data word, and a read returns the kept bits. The LED bar (0x408, also driven on `led_bar`), the break byte (0x508, on `brk_val`) and the GP output byte (0xA00, on `gp_out`) each keep wdata[7:0]. The I2C enable register (0xB08, on `i2c_oe`) keeps wdata[1:0]. The loopback select (0xB18) keeps wdata[0].
- R5: A write to 0x410 sets display character k (k = 0..7, held in `disp_text[8k+7:8k]`) to the uppercase ASCII hex digit of wdata[31-4k:28-4k]. Character 0 therefore shows the most significant digit.
- R6: A write to offset 0x418 + 8k (k = 0..7) sets character k to wdata[7:0]. Other characters keep their values. An offset inside that range that is not a multiple of 8 is unmapped.
- R7: `disp_update` is high for exactly the one cycle after a display write (R5 or R6). It stays low otherwise.
- R8: A write of exactly 0x00000042 to 0x500 makes `soft_reset_req` high for the following cycle. Any other value written there leaves it low.
- R9: A write to 0xB10 stores the full 32-bit word and reads back whole. `i2c_scl` presents stored bit 1 and `i2c_sda` presents stored bit 0. `i2c_wr_stb` is high for the one cycle after the write.
- R10: The loopback input (0xA08) reads the stored 0xB10 word when the select bit is 1, and 0 when it is 0.
- R11: The I2C input word (0xB00) reads as the held input word 0x3 with bit 0 replaced by `eeprom_sda_in`, sampled in the read-request cycle.
- R12: After synchronous reset the registers hold these values:

  | Register | Reset value |
  |---|---|
  | LED bar | 0x00 |
  | break byte | 0x0A |
  | GP output | 0x00 |
  | I2C enable | 0 |
  | 0xB10 word | 0x3 |
  | select bit | 1 |
  | each display character | 0x20 (ASCII space) |

  All pulses and `bus_rvalid` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | ADDR_W | Byte address; bits [19:0] decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| soft_reset_req | output | 1 | One-cycle soft-reset request |
| led_bar | output | 8 | LED bar pattern |
| brk_val | output | 8 | Break/reset byte |
| gp_out | output | 8 | General-purpose output byte |
| disp_text | output | 64 | Display characters, character k in bits [8k+7:8k] |
| disp_update | output | 1 | One-cycle pulse after a display change |
| i2c_scl | output | 1 | Clock line toward the EEPROM |
| i2c_sda | output | 1 | Data line toward the EEPROM |
| i2c_oe | output | 2 | I2C line enable bits |
| i2c_wr_stb | output | 1 | One-cycle strobe after a 0xB10 write |
| eeprom_sda_in | input | 1 | Data line sampled from the EEPROM |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume that bus inputs stay steady around each clock edge. The bench drives every request for exactly one cycle, changes inputs only on the falling edge, and puts at least one idle cycle between requests. This keeps each registered read and each one-cycle pulse separate, so both can be observed. Addresses with upper bits set are applied on purpose, to show that those bits play no part in the decode.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int DEC_W   = 20;
    localparam int N_CHARS = 8;
    localparam int IDX_W   = $clog2(N_CHARS);

    localparam logic [DEC_W-1:0] OFF_SWITCH  = 20'h00200;
    localparam logic [DEC_W-1:0] OFF_STATUS  = 20'h00208;
    localparam logic [DEC_W-1:0] OFF_JUMPER  = 20'h00210;
    localparam logic [DEC_W-1:0] OFF_LED     = 20'h00408;
    localparam logic [DEC_W-1:0] OFF_HEXWORD = 20'h00410;
    localparam logic [DEC_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [DEC_W-1:0] OFF_SOFTRES = 20'h00500;
    localparam logic [DEC_W-1:0] OFF_BRK     = 20'h00508;
    localparam logic [DEC_W-1:0] OFF_GPOUT   = 20'h00a00;
    localparam logic [DEC_W-1:0] OFF_LOOPIN  = 20'h00a08;
    localparam logic [DEC_W-1:0] OFF_I2CIN   = 20'h00b00;
    localparam logic [DEC_W-1:0] OFF_I2COE   = 20'h00b08;
    localparam logic [DEC_W-1:0] OFF_I2COUT  = 20'h00b10;
    localparam logic [DEC_W-1:0] OFF_I2CSEL  = 20'h00b18;

    localparam logic [31:0] SOFTRES_KEY = 32'h0000_0042;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SWITCH, SEL_STATUS, SEL_JUMPER, SEL_LED, SEL_HEXWORD,
        SEL_CHAR, SEL_SOFTRES, SEL_BRK, SEL_GPOUT, SEL_LOOPIN, SEL_I2CIN,
        SEL_I2COE, SEL_I2COUT, SEL_I2CSEL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [DEC_W-1:0] a);
        dec_t d;
        logic [DEC_W-1:0] rel;
        d.sel = SEL_NONE;
        d.idx = '0;
        rel   = a - OFF_CHAR0;
        case (a)
            OFF_SWITCH:  d.sel = SEL_SWITCH;
            OFF_STATUS:  d.sel = SEL_STATUS;
            OFF_JUMPER:  d.sel = SEL_JUMPER;
            OFF_LED:     d.sel = SEL_LED;
            OFF_HEXWORD: d.sel = SEL_HEXWORD;
            OFF_SOFTRES: d.sel = SEL_SOFTRES;
            OFF_BRK:     d.sel = SEL_BRK;
            OFF_GPOUT:   d.sel = SEL_GPOUT;
            OFF_LOOPIN:  d.sel = SEL_LOOPIN;
            OFF_I2CIN:   d.sel = SEL_I2CIN;
            OFF_I2COE:   d.sel = SEL_I2COE;
            OFF_I2COUT:  d.sel = SEL_I2COUT;
            OFF_I2CSEL:  d.sel = SEL_I2CSEL;
            default: begin
                if (a >= OFF_CHAR0 && rel < DEC_W'(8 * N_CHARS) && rel[2:0] == 3'b000) begin
                    d.sel = SEL_CHAR;
                    d.idx = rel[IDX_W+2:3];
                end
            end
        endcase
        return d;
    endfunction

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/bcr_display.sv
module bcr_display
    import board_ctl_pkg::*;
#(
    parameter int NCH = N_CHARS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_we,
    input  logic                 char_we,
    input  logic [IDX_W-1:0]     char_idx,
    input  logic [31:0]          wdata,
    output logic [8*NCH-1:0]     text,
    output logic                 update
);

    for (genvar k = 0; k < NCH; k++) begin : g_char
        always_ff @(posedge clk) begin
            if (rst) begin
                text[8*k +: 8] <= 8'h20;
            end else if (word_we) begin
                text[8*k +: 8] <= hex_char(wdata[4*(NCH-1-k) +: 4]);
            end else if (char_we && char_idx == IDX_W'(k)) begin
                text[8*k +: 8] <= wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) update <= 1'b0;
        else     update <= word_we | char_we;
    end

    // R7: every display write is followed by exactly one update pulse
    a_r7_update_pulse: assert property (@(posedge clk) disable iff (rst)
        (word_we || char_we) |=> update);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(word_we || char_we) |=> !update);
    // R6: a per-character write leaves the neighbouring character alone
    a_r6_neighbour_kept: assert property (@(posedge clk) disable iff (rst)
        (char_we && !word_we && char_idx != '0) |=> $stable(text[7:0]));

endmodule

// File: rtl/bcr_i2c_regs.sv
module bcr_i2c_regs (
    input  logic        clk,
    input  logic        rst,
    input  logic        we_out,
    input  logic        we_oe,
    input  logic        we_sel,
    input  logic [31:0] wdata,
    input  logic        sda_in,
    output logic [31:0] out_q,
    output logic [1:0]  oe_q,
    output logic        sel_q,
    output logic [31:0] in_word,
    output logic        loop_word_nz,
    output logic [31:0] loop_word,
    output logic        scl,
    output logic        sda,
    output logic        wr_stb
);

    logic [31:0] in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= 32'h3;
            oe_q   <= 2'b00;
            sel_q  <= 1'b1;
            in_q   <= 32'h3;
            wr_stb <= 1'b0;
        end else begin
            if (we_out) out_q <= wdata;
            if (we_oe)  oe_q  <= wdata[1:0];
            if (we_sel) sel_q <= wdata[0];
            wr_stb <= we_out;
        end
    end

    assign scl          = out_q[1];
    assign sda          = out_q[0];
    assign in_word      = {in_q[31:1], sda_in};
    assign loop_word    = sel_q ? out_q : 32'h0;
    assign loop_word_nz = |loop_word;

    // R9: one strobe per line write, and the lines follow the written bits
    a_r9_strobe: assert property (@(posedge clk) disable iff (rst)
        we_out |=> (wr_stb && scl == $past(wdata[1]) && sda == $past(wdata[0])));
    a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !we_out |=> (!wr_stb && $stable(out_q)));

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              soft_reset_req,
    output logic [7:0]        led_bar,
    output logic [7:0]        brk_val,
    output logic [7:0]        gp_out,
    output logic [8*N_CHARS-1:0] disp_text,
    output logic              disp_update,
    output logic              i2c_scl,
    output logic              i2c_sda,
    output logic [1:0]        i2c_oe,
    output logic              i2c_wr_stb,
    input  logic              eeprom_sda_in
);

    localparam logic [31:0] STATUS_WORD = BIG_ENDIAN ? 32'h12 : 32'h10;

    dec_t dec;
    assign dec = decode(bus_addr[DEC_W-1:0]);

    function automatic logic wr_hit(input logic wr, input reg_sel_e s, input reg_sel_e want);
        return wr && (s == want);
    endfunction

    logic [31:0] i2c_out_q, i2c_in_word, loop_word;
    logic [1:0]  i2c_oe_q;
    logic        i2c_sel_q, loop_nz;

    bcr_display #(.NCH(N_CHARS)) u_disp (
        .clk      (clk),
        .rst      (rst),
        .word_we  (wr_hit(bus_wr, dec.sel, SEL_HEXWORD)),
        .char_we  (wr_hit(bus_wr, dec.sel, SEL_CHAR)),
        .char_idx (dec.idx),
        .wdata    (bus_wdata),
        .text     (disp_text),
        .update   (disp_update)
    );

    bcr_i2c_regs u_i2c (
        .clk          (clk),
        .rst          (rst),
        .we_out       (wr_hit(bus_wr, dec.sel, SEL_I2COUT)),
        .we_oe        (wr_hit(bus_wr, dec.sel, SEL_I2COE)),
        .we_sel       (wr_hit(bus_wr, dec.sel, SEL_I2CSEL)),
        .wdata        (bus_wdata),
        .sda_in       (eeprom_sda_in),
        .out_q        (i2c_out_q),
        .oe_q         (i2c_oe_q),
        .sel_q        (i2c_sel_q),
        .in_word      (i2c_in_word),
        .loop_word_nz (loop_nz),
        .loop_word    (loop_word),
        .scl          (i2c_scl),
        .sda          (i2c_sda),
        .wr_stb       (i2c_wr_stb)
    );

    assign i2c_oe = i2c_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_bar        <= 8'h00;
            brk_val        <= 8'h0a;
            gp_out         <= 8'h00;
            soft_reset_req <= 1'b0;
        end else begin
            if (wr_hit(bus_wr, dec.sel, SEL_LED))   led_bar <= bus_wdata[7:0];
            if (wr_hit(bus_wr, dec.sel, SEL_BRK))   brk_val <= bus_wdata[7:0];
            if (wr_hit(bus_wr, dec.sel, SEL_GPOUT)) gp_out  <= bus_wdata[7:0];
            soft_reset_req <= wr_hit(bus_wr, dec.sel, SEL_SOFTRES) && bus_wdata == SOFTRES_KEY;
        end
    end

    logic [31:0] rd_mux;
    always_comb begin
        case (dec.sel)
            SEL_STATUS: rd_mux = STATUS_WORD;
            SEL_LED:    rd_mux = {24'h0, led_bar};
            SEL_BRK:    rd_mux = {24'h0, brk_val};
            SEL_GPOUT:  rd_mux = {24'h0, gp_out};
            SEL_LOOPIN: rd_mux = loop_word;
            SEL_I2CIN:  rd_mux = i2c_in_word;
            SEL_I2COE:  rd_mux = {30'h0, i2c_oe_q};
            SEL_I2COUT: rd_mux = i2c_out_q;
            SEL_I2CSEL: rd_mux = {31'h0, i2c_sel_q};
            default:    rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= 32'h0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : 32'h0;
        end
    end

    // R3: fixed one-cycle read latency
    a_r3_rvalid: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    a_r3_no_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);
    // R8: the key raises the request, anything else keeps it low
    a_r8_softres: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.sel == SEL_SOFTRES && bus_wdata == SOFTRES_KEY) |=> soft_reset_req);
    a_r8_no_softres: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && dec.sel == SEL_SOFTRES && bus_wdata == SOFTRES_KEY) |=> !soft_reset_req);
    // R4: the LED bar holds its value unless its own offset is written
    a_r4_led_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && dec.sel == SEL_LED) |=> $stable(led_bar));
    // R10: loopback reads nothing while the select bit is clear
    a_r10_loop_off: assert property (@(posedge clk) disable iff (rst)
        !i2c_sel_q |-> !loop_nz);

endmodule

// File: tb/board_ctl_regs_tb.sv
module board_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, soft_reset_req, disp_update;
    logic        i2c_scl, i2c_sda, i2c_wr_stb;
    logic [1:0]  i2c_oe;
    logic [7:0]  led_bar, brk_val, gp_out;
    logic [63:0] disp_text;
    logic        eeprom_sda_in = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    board_ctl_regs u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .soft_reset_req(soft_reset_req),
        .led_bar(led_bar), .brk_val(brk_val), .gp_out(gp_out),
        .disp_text(disp_text), .disp_update(disp_update),
        .i2c_scl(i2c_scl), .i2c_sda(i2c_sda), .i2c_oe(i2c_oe),
        .i2c_wr_stb(i2c_wr_stb), .eeprom_sda_in(eeprom_sda_in)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    // write then read back at the same address
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0408, 32'h1234_56a5, 32'h0000_00a5},  // R4 LED keeps low byte
        '{32'h0000_0508, 32'hffff_ff3c, 32'h0000_003c},  // R4 break byte
        '{32'h0000_0a00, 32'h0000_01ff, 32'h0000_00ff},  // R4 GP output
        '{32'h0000_0b08, 32'hffff_ffff, 32'h0000_0003},  // R4 enable two bits
        '{32'h0000_0b18, 32'hffff_fffe, 32'h0000_0000},  // R4 select one bit
        '{32'h0000_0200, 32'hffff_ffff, 32'h0000_0000},  // R2 switch
        '{32'h0000_0210, 32'hffff_ffff, 32'h0000_0000},  // R2 jumper
        '{32'h0000_0208, 32'hffff_ffff, 32'h0000_0010},  // R2 status
        '{32'h0000_0300, 32'hffff_ffff, 32'h0000_0000},  // R1 unmapped
        '{32'hfff0_0408, 32'h0000_0077, 32'h0000_0077},  // R1 upper bits ignored
        '{32'h0000_0b10, 32'hdead_bee2, 32'hdead_bee2}   // R9 full word
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk("R12 led", {56'h0, led_bar}, 64'h00);
        chk("R12 brk", {56'h0, brk_val}, 64'h0a);
        chk("R12 gpout", {56'h0, gp_out}, 64'h00);
        chk("R12 oe", {62'h0, i2c_oe}, 64'h0);
        chk("R12 lines", {62'h0, i2c_scl, i2c_sda}, 64'h3);
        chk("R12 display", disp_text, 64'h2020_2020_2020_2020);
        chk("R12 pulses", {61'h0, soft_reset_req, disp_update, i2c_wr_stb}, 64'h0);
        chk("R12 rvalid", {63'h0, bus_rvalid}, 64'h0);
        bus_read(32'h0b10, rd, v);
        chk("R12 i2cout reset", {32'h0, rd}, 64'h3);
        chk("R3 rvalid", {63'h0, v}, 64'h1);
        bus_read(32'h0b18, rd, v);
        chk("R12 select reset", {32'h0, rd}, 64'h1);
        bus_read(32'h0a08, rd, v);
        chk("R10 loopback on", {32'h0, rd}, 64'h3);
        eeprom_sda_in = 1'b1;
        bus_read(32'h0b00, rd, v);
        chk("R11 input sda=1", {32'h0, rd}, 64'h3);
        eeprom_sda_in = 1'b0;
        bus_read(32'h0b00, rd, v);
        chk("R11 input sda=0", {32'h0, rd}, 64'h2);
        @(negedge clk);
        chk("R3 rvalid drops", {63'h0, bus_rvalid}, 64'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, rd, v);
            chk($sformatf("R1/R2/R4/R9 vector %0d", i), {31'h0, v, rd}, {32'h1, VECS[i].exp});
        end
        chk("R4 led port", {56'h0, led_bar}, 64'h77);
        chk("R4 brk port", {56'h0, brk_val}, 64'h3c);
        chk("R4 gp port", {56'h0, gp_out}, 64'hff);
        chk("R4 oe port", {62'h0, i2c_oe}, 64'h3);
        chk("R9 lines", {62'h0, i2c_scl, i2c_sda}, 64'h2);
        bus_read(32'h0a08, rd, v);
        chk("R10 loopback off", {32'h0, rd}, 64'h0);
        bus_write(32'h0b18, 32'h1);
        bus_read(32'h0a08, rd, v);
        chk("R10 loopback on again", {32'h0, rd}, 64'hdead_bee2);

        // R9 strobe timing
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 32'h0b10; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 strobe high", {63'h0, i2c_wr_stb}, 64'h1);
        chk("R9 lines 01", {62'h0, i2c_scl, i2c_sda}, 64'h1);
        @(negedge clk);
        chk("R9 strobe one cycle", {63'h0, i2c_wr_stb}, 64'h0);

        // R5 hex word
        bus_write(32'h0410, 32'h0a1b_2c3d);
        chk("R5 hex text", disp_text, 64'h4433_4332_4231_4130);
        chk("R7 update pulse", {63'h0, disp_update}, 64'h1);
        @(negedge clk);
        chk("R7 update one cycle", {63'h0, disp_update}, 64'h0);
        bus_write(32'h0410, 32'hfedc_9876);
        chk("R5 hex text 2", disp_text, 64'h3637_3839_4344_4546);

        // R6 per-character
        bus_write(32'h0450, 32'h0000_005a);
        chk("R6 char 7", disp_text, 64'h5a37_3839_4344_4546);
        bus_write(32'h0418, 32'h0000_0161);
        chk("R6 char 0", disp_text, 64'h5a37_3839_4344_4561);
        chk("R7 update char", {63'h0, disp_update}, 64'h1);
        bus_write(32'h041c, 32'h0000_0000);
        chk("R6 misaligned ignored", disp_text, 64'h5a37_3839_4344_4561);
        chk("R7 no update misaligned", {63'h0, disp_update}, 64'h0);
        bus_read(32'h0410, rd, v);
        chk("R2 write-only reads 0", {32'h0, rd}, 64'h0);

        // R8 soft reset key
        bus_write(32'h0500, 32'h0000_0043);
        chk("R8 wrong key", {63'h0, soft_reset_req}, 64'h0);
        bus_write(32'h0000_0500 | 32'h0010_0000, 32'h0000_0042);
        chk("R8 key pulse", {63'h0, soft_reset_req}, 64'h1);
        @(negedge clk);
        chk("R8 pulse one cycle", {63'h0, soft_reset_req}, 64'h0);
        bus_write(32'h0500, 32'h0100_0042);
        chk("R8 upper bits spoil key", {63'h0, soft_reset_req}, 64'h0);

        // R1 unmapped write leaves outputs alone
        bus_write(32'h0004_0408, 32'h0000_0011);
        chk("R1 unmapped write", {40'h0, led_bar, brk_val, gp_out}, {40'h0, 8'h77, 8'h3c, 8'hff});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule